// File: doc/BRIEF.md
# Synchronous Serial Master with Automatic Block Transfer

This block drives a three-wire synchronous serial link as clock master. The link has a shift clock, a data output and a data input. An internal down-counter sets each half of the shift-clock period. A single control input chooses whether each byte goes out with its least or its most significant bit first. Received bits are placed using the same bit order.

A start pulse launches a transfer. In single-byte mode exactly eight bits are exchanged. In burst mode the programmed count gives any length from 1 to 256 bits. Data moves through a byte-wide buffer port that has read and write strobes. Before each byte the block fetches the byte to send from the current buffer address. After each byte it writes the received byte back to the same address. The address then steps to the next byte.

A suspend pulse lets the current byte and its store finish, then parks the link with the clock high. A later start pulse resumes the transfer from the next byte. When the final bit has been stored, the block raises a done flag and drops its running indication.

Top module: `ssp_block`

## Requirements
- R1: After reset the shift clock is high, no transfer is running or paused, done is low, and neither buffer strobe is active.
- R2: The shift clock idles high. The data output changes only in the cycle where the shift clock falls, and the data input is captured when the shift clock rises.
- R3: With divider value D, each low half and each high half of the shift clock lasts D+1 cycles.
- R4: Within each byte, the k-th transferred bit (k = 0..7) uses bit position k when LSB-first is selected (msb_first_i = 0) and bit position 7-k when MSB-first is selected (msb_first_i = 1). This holds for both the sent and the received bits.
- R5: With burst_i = 0, a transfer exchanges exactly 8 bits, regardless of len_m1_i. It performs one fetch and one store, both at address 0.
- R6: With burst_i = 1, a transfer exchanges len_m1_i+1 bits (0 gives 1 bit, 255 gives 256 bits). Byte j is fetched from address j and stored back to address j.
- R7: A final partial byte is stored with its received bits in their R4 positions and all bit positions not transferred set to zero.
- R8: Between two bytes, the store of the finished byte comes before the fetch of the next one, and the shift clock stays high during both.
- R9: After the last store, done_o goes high and run_o goes low. The next start pulse clears done_o.
- R10: A suspend pulse during a transfer lets the current byte and its store complete, then sets paused_o with the clock high and no fetch. A start pulse then resumes the transfer at the next byte.
- R11: A start pulse while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; resumes when paused |
| suspend_i | input | 1 | Request to pause at the next byte boundary |
| burst_i | input | 1 | 1 = programmed bit count, 0 = single byte |
| msb_first_i | input | 1 | Bit order select |
| baud_div_i | input | DIV_W | Half-period divider D |
| len_m1_i | input | LEN_W | Bit count minus one (burst mode) |
| sdi_i | input | 1 | Serial data in |
| sck_o | output | 1 | Shift clock |
| sdo_o | output | 1 | Serial data out |
| buf_addr_o | output | LEN_W-3 | Buffer byte address |
| buf_rd_o | output | 1 | Fetch strobe; buf_rdata_i is read in this cycle |
| buf_rdata_i | input | 8 | Byte to send |
| buf_wr_o | output | 1 | Store strobe |
| buf_wdata_o | output | 8 | Received byte |
| run_o | output | 1 | Transfer active |
| paused_o | output | 1 | Transfer parked at a byte boundary |
| done_o | output | 1 | Last transfer completed |

## Verification
The hardest state to reach is a parked transfer. Getting there needs a suspend pulse that arrives mid-byte. The block must finish that byte, store it, and then not fetch again. The stimulus counts observed shift-clock rises, pulses suspend part way through the first byte, and holds the block idle for many cycles before resuming. The scoreboard then still expects every remaining bit and store in order. A burst that ends mid-byte under each bit order covers the zero padding of partial stores.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOW, ST_HIGH, ST_STORE, ST_HOLD
  } ssp_state_e;

  // bit position inside a byte for the k-th transferred bit
  function automatic logic [2:0] lane_of(input logic [2:0] k, input logic msb);
    return msb ? (3'd7 - k) : k;
  endfunction
endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (reload_i)     cnt_q <= div_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);

  AST_TICK_AFTER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i && div_i != '0) |=> !tick_o); // R3
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] idx_o,
  output logic             last_o,
  output logic             byte_end_o
);
  logic [LEN_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       idx_q <= '0;
    else if (clear_i) idx_q <= '0;
    else if (step_i)  idx_q <= idx_q + 1'b1;
  end

  assign idx_o      = idx_q;
  assign last_o     = (idx_q == len_i);
  assign byte_end_o = (&idx_q[2:0]) || last_o;

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= len_i); // R6
endmodule

// File: rtl/ssp_lane.sv
module ssp_lane
  import ssp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] din_i,
  input  logic              sample_i,
  input  logic              sdi_i,
  input  logic              drive_i,
  input  logic [2:0]        lane_i,
  input  logic [2:0]        drive_lane_i,
  output logic              sdo_o,
  output logic [BYTE_W-1:0] rx_o
);
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic              sdo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      sdo_q <= 1'b1;
    end else if (load_i) begin
      tx_q  <= din_i;
      rx_q  <= '0;
      sdo_q <= din_i[lane_i];
    end else begin
      if (sample_i) rx_q[lane_i] <= sdi_i;
      if (drive_i)  sdo_q <= tx_q[drive_lane_i];
    end
  end

  assign sdo_o = sdo_q;
  assign rx_o  = rx_q;
endmodule

// File: rtl/ssp_block.sv
module ssp_block
  import ssp_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             suspend_i,
  input  logic             burst_i,
  input  logic             msb_first_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic [LEN_W-1:0] len_m1_i,
  input  logic             sdi_i,
  output logic             sck_o,
  output logic             sdo_o,
  output logic [LEN_W-4:0] buf_addr_o,
  output logic             buf_rd_o,
  input  logic [7:0]       buf_rdata_i,
  output logic             buf_wr_o,
  output logic [7:0]       buf_wdata_o,
  output logic             run_o,
  output logic             paused_o,
  output logic             done_o
);
  localparam int unsigned ADDR_W = LEN_W - 3;

  ssp_state_e       state_q, state_d;
  logic             cfg_msb;
  logic [DIV_W-1:0] cfg_div;
  logic [LEN_W-1:0] cfg_len;
  logic             susp_pend, done_q;

  logic             tick, last_bit, byte_end;
  logic [LEN_W-1:0] idx;
  logic [2:0]       lane_now, lane_next;
  logic [7:0]       rx_byte;

  // named internal events
  logic ev_launch, ev_load, ev_sample, ev_drive, ev_store, ev_step, ev_finish;

  assign ev_launch = (state_q == ST_IDLE) && start_i;
  assign ev_load   = (state_q == ST_FETCH);
  assign ev_sample = (state_q == ST_LOW) && tick;
  assign ev_drive  = (state_q == ST_HIGH) && tick && !byte_end;
  assign ev_store  = (state_q == ST_STORE);
  assign ev_finish = ev_store && last_bit;
  assign ev_step   = ev_drive || (ev_store && !last_bit);

  assign lane_now  = lane_of(idx[2:0], cfg_msb);
  assign lane_next = lane_of(idx[2:0] + 3'd1, cfg_msb);

  ssp_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n),
    .reload_i(ev_load || ev_sample || ev_drive),
    .div_i(cfg_div), .tick_o(tick)
  );

  ssp_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clear_i(ev_launch), .step_i(ev_step),
    .len_i(cfg_len), .idx_o(idx), .last_o(last_bit), .byte_end_o(byte_end)
  );

  ssp_lane u_lane (
    .clk(clk), .rst_n(rst_n), .load_i(ev_load), .din_i(buf_rdata_i),
    .sample_i(ev_sample), .sdi_i(sdi_i), .drive_i(ev_drive),
    .lane_i(lane_now), .drive_lane_i(lane_next),
    .sdo_o(sdo_o), .rx_o(rx_byte)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_LOW;
      ST_LOW:   if (tick) state_d = ST_HIGH;
      ST_HIGH:  if (tick) state_d = byte_end ? ST_STORE : ST_LOW;
      ST_STORE: state_d = last_bit ? ST_IDLE : (susp_pend ? ST_HOLD : ST_FETCH);
      ST_HOLD:  if (start_i) state_d = ST_FETCH;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cfg_msb   <= 1'b0;
      cfg_div   <= '0;
      cfg_len   <= '0;
      susp_pend <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_launch) begin
        cfg_msb <= msb_first_i;
        cfg_div <= baud_div_i;
        cfg_len <= burst_i ? len_m1_i : LEN_W'(7);
        done_q  <= 1'b0;
      end
      if (ev_finish) done_q <= 1'b1;
      unique case (state_q)
        ST_IDLE, ST_HOLD: susp_pend <= 1'b0;
        ST_STORE:         susp_pend <= (last_bit || susp_pend) ? 1'b0 : suspend_i;
        default:          susp_pend <= susp_pend | suspend_i;
      endcase
    end
  end

  assign sck_o       = (state_q != ST_LOW);
  assign buf_addr_o  = idx[LEN_W-1:3];
  assign buf_rd_o    = ev_load;
  assign buf_wr_o    = ev_store;
  assign buf_wdata_o = rx_byte;
  assign run_o       = (state_q != ST_IDLE) && (state_q != ST_HOLD);
  assign paused_o    = (state_q == ST_HOLD);
  assign done_o      = done_q;

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_o) |-> $fell(sck_o)); // R2
  AST_STROBE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd_o || buf_wr_o) |-> sck_o); // R8
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (!run_o && $past(buf_wr_o))); // R9
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (paused_o && $past(paused_o)) |-> (sck_o && $stable(sdo_o))); // R10
  AST_ADDR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_o |-> (idx[2:0] == 3'd0)); // R6
  initial assert (ADDR_W >= 1);
endmodule

// File: tb/ssp_block_test.sv
module ssp_block_test;
  localparam int DIV_W = 8;
  localparam int LEN_W = 8;
  localparam int AW = LEN_W - 3;
  localparam int NB = 1 << AW;
  localparam int NBITS = 1 << LEN_W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 0, suspend = 0, burst = 0, msb = 0, sdi = 0;
  logic [DIV_W-1:0] div = '0;
  logic [LEN_W-1:0] len_m1 = '0;
  logic sck, sdo, buf_rd, buf_wr, run, paused, done;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_rdata, buf_wdata;

  logic [7:0] tx_mem [NB];
  logic rx_bits [NBITS];
  assign buf_rdata = tx_mem[buf_addr];

  ssp_block #(.DIV_W(DIV_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .suspend_i(suspend),
    .burst_i(burst), .msb_first_i(msb), .baud_div_i(div), .len_m1_i(len_m1),
    .sdi_i(sdi), .sck_o(sck), .sdo_o(sdo), .buf_addr_o(buf_addr),
    .buf_rd_o(buf_rd), .buf_rdata_i(buf_rdata), .buf_wr_o(buf_wr),
    .buf_wdata_o(buf_wdata), .run_o(run), .paused_o(paused), .done_o(done)
  );

  int checks = 0, errors = 0;
  int bit_i = 0, fetch_n = 0, store_n = 0, low_len = 0, cur_div = 0;
  int n_bits = 0, n_bytes = 0;
  logic prev_sck = 1'b1;
  logic [AW+7:0] st_q [$];
  logic sdo_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // monitor: scoreboard pops expected items as results appear
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sck = 1'b1;
      low_len = 0;
      sdi = 1'b0;
    end else begin
      if (!sck) low_len++;
      if (prev_sck && !sck) sdi = (bit_i < NBITS) ? rx_bits[bit_i] : 1'b0;
      if (!prev_sck && sck) begin
        chk(low_len == cur_div + 1, "R3 low half length", low_len, cur_div + 1);
        if (sdo_q.size() == 0) chk(0, "R6 surplus bit", bit_i, n_bits);
        else begin
          logic e;
          e = sdo_q.pop_front();
          chk(sdo == e, "R2/R4 sent bit", int'(sdo), int'(e));
        end
        bit_i++;
        low_len = 0;
      end
      if (buf_rd) begin
        chk(int'(buf_addr) == fetch_n, "R6 fetch address", buf_addr, fetch_n);
        chk(store_n == fetch_n, "R8 store precedes fetch", store_n, fetch_n);
        fetch_n++;
      end
      if (buf_wr) begin
        if (st_q.size() == 0) chk(0, "R6 surplus store", store_n, n_bytes);
        else begin
          logic [AW+7:0] e;
          e = st_q.pop_front();
          chk({buf_addr, buf_wdata} == e, "R4/R7 stored byte",
              int'({buf_addr, buf_wdata}), int'(e));
        end
        store_n++;
      end
      prev_sck = sck;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // driver: pushes the expected bits and stores, then launches
  task automatic xfer_begin(input bit b, input bit m, input int d, input int l);
    n_bits = b ? l + 1 : 8;
    n_bytes = (n_bits + 7) / 8;
    for (int i = 0; i < n_bits; i++)
      sdo_q.push_back(tx_mem[i / 8][m ? 7 - (i % 8) : (i % 8)]);
    for (int j = 0; j < n_bytes; j++) begin
      logic [7:0] v;
      v = 8'h00;
      for (int k = 0; k < 8; k++)
        if (j * 8 + k < n_bits) v[m ? 7 - k : k] = rx_bits[j * 8 + k];
      st_q.push_back({AW'(j), v});
    end
    @(negedge clk);
    burst = b; msb = m; div = DIV_W'(d); len_m1 = LEN_W'(l);
    cur_div = d; bit_i = 0; fetch_n = 0; store_n = 0;
    pulse_start();
    chk(run == 1'b1 && done == 1'b0, "R9 start clears done", int'(done), 0);
  endtask

  task automatic xfer_end(input string tag);
    int waited;
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1 && run == 1'b0, "R9 done and idle", int'(run), 0);
    chk(bit_i == n_bits, tag, bit_i, n_bits);
    chk(store_n == n_bytes && fetch_n == n_bytes, tag, store_n, n_bytes);
    chk(st_q.size() == 0 && sdo_q.size() == 0, tag, st_q.size(), 0);
    chk(sck == 1'b1, "R2 clock idles high", int'(sck), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    for (int j = 0; j < NB; j++) tx_mem[j] = 8'((j * 37 + 90) ^ (j << 3));
    for (int i = 0; i < NBITS; i++) rx_bits[i] = (((i * 13 + 5) % 7) < 3);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sck == 1 && run == 0 && done == 0 && paused == 0 && buf_rd == 0 && buf_wr == 0,
        "R1 reset state", int'({sck, run, done, paused}), 8);

    xfer_begin(0, 0, 0, 200); xfer_end("R5 single byte LSB first");
    xfer_begin(0, 1, 3, 0);   xfer_end("R5 single byte MSB first");
    xfer_begin(1, 0, 0, 0);   xfer_end("R7 one-bit burst");
    xfer_begin(1, 1, 1, 2);   xfer_end("R7 three-bit burst MSB");
    xfer_begin(1, 1, 1, 19);  xfer_end("R6 twenty-bit burst");
    xfer_begin(1, 0, 0, 255); xfer_end("R6 full 256-bit burst");

    // R10: suspend mid-byte, stay parked, then resume
    xfer_begin(1, 0, 2, 23);
    while (bit_i < 3) @(negedge clk);
    suspend = 1'b1;
    @(negedge clk) suspend = 1'b0;
    begin
      int w;
      w = 0;
      while (!paused && w < 2000) begin @(negedge clk); w++; end
    end
    chk(paused == 1 && run == 0 && sck == 1, "R10 parked with clock high",
        int'({paused, run, sck}), 5);
    chk(store_n == 1 && fetch_n == 1, "R10 current byte stored only", store_n, 1);
    begin
      int hi;
      hi = 0;
      repeat (40) begin @(negedge clk); if (sck) hi++; end
      chk(hi == 40 && fetch_n == 1 && bit_i == 8, "R10 no activity while parked", fetch_n, 1);
    end
    pulse_start();
    chk(paused == 0 && run == 1, "R10 resumed", int'(paused), 0);
    xfer_end("R10 resumed transfer complete");

    // R11: start during a running transfer is ignored
    xfer_begin(1, 1, 1, 15);
    while (bit_i < 5) @(negedge clk);
    pulse_start();
    xfer_end("R11 start while running ignored");
    chk(fetch_n == 2, "R11 fetch count", fetch_n, 2);

    summary();
    $finish;
  end
endmodule